// File: doc/BRIEF.md
# Temperature Sensor Measurement Sequencer

This block runs one temperature-sensor measurement each time software asks for one. Software sets a start flag, a settling-time select and a 4-bit trim value in a control register. The sequencer latches the trim and drives it to the sensor. It then waits out a settling period of 4 or 12 microseconds, counted in system clocks. After that it samples the sensor's 10-bit code into a result register and sets a ready flag. An interrupt line follows the ready flag when software has enabled it.

Two bits from a control word that other logic shares gate the sequencer: a sensor enable and a sensor reset. The sequencer finishes in a completion state and stays there until software drops the start flag, which software does after reading the result. Registers sit behind a simple word-indexed write port with a combinational read port. Index 0 is control, index 1 is status and index 2 is the result.

Top module: `tsen_seq`

## Requirements
- R1: After reset all registers read zero, the interrupt and sample outputs are low and the trim output is zero.
- R2: Control register (index 0): bit 8 is start, bit 21 selects the settling time (0 is the short wait, 1 is the long wait) and bits 25:22 hold the trim. These fields read back as written, and every other bit reads zero.
- R3: When start is written while the sensor is enabled and not held in reset, the ready flag reads one exactly LIM+2 clock edges after the write edge. LIM is SHORT_US or LONG_US multiplied by the clock frequency in MHz.
- R4: The sensor code is sampled during a single-cycle high pulse on sample_o. It appears in bits 9:0 of the result register (index 2), and bits 31:10 read zero. The ready flag is set on the edge that ends that pulse.
- R5: Status register (index 1): bit 0 is ready and bit 1 is interrupt enable. Writing bit 0 as zero clears ready. Writing it as one never sets ready.
- R6: irq_o is high exactly when ready and interrupt enable are both set.
- R7: While start stays high after a completed measurement, no further measurement happens. After start goes low, a new start begins a new measurement.
- R8: trim_o takes the trim field when a measurement starts and holds that value until the next start, whatever is later written to the control register.
- R9: While the sensor reset input is high, the sequencer is held idle. A measurement in progress is abandoned without sampling and without setting ready.
- R10: While the sensor enable input is low, a start is not accepted. Once enable rises with start still set, the measurement begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index (0 control, 1 status, 2 result) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| sens_en_i | input | 1 | Sensor enable from the shared control word |
| sens_rst_i | input | 1 | Sensor reset from the shared control word |
| code_i | input | 10 | Sensor output code |
| trim_o | output | 4 | Trim value driven to the sensor |
| sample_o | output | 1 | One-cycle pulse when the code is captured |
| irq_o | output | 1 | Measurement-complete interrupt |

## Verification
The bench counts clock edges from the start write to the ready flag for both settling selects. An off-by-one in the settle counter, or a select that is inverted, shows up as a wrong edge count. The bench holds start high after completion and counts sample pulses. A sequencer that leaves the completion state on its own would produce a second capture. Other cases rewrite the trim field mid-measurement, pulse the sensor reset during settling and start with the sensor disabled. A design that fails to latch the trim would show the new trim, and one that ignores the sensor reset or enable would capture a code anyway. Writing one to the ready bit while it is clear catches a flag that software can set.

// File: rtl/tsen_pkg.sv
package tsen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_DONE   = 2'd3
  } tsen_state_e;

  localparam int DATA_W        = 32;
  localparam int CODE_W        = 10;
  localparam int TRIM_W        = 4;
  localparam int IDX_W         = 2;

  localparam int CTL_START_BIT = 8;
  localparam int CTL_SEL_BIT   = 21;
  localparam int CTL_TRIM_LSB  = 22;
  localparam int STS_RDY_BIT   = 0;
  localparam int STS_IE_BIT    = 1;

  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 2'd1;
  localparam logic [IDX_W-1:0] IDX_RES  = 2'd2;
endpackage

// File: rtl/tsen_rst_sync.sv
module tsen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q[0] <= 1'b0;
        else          sync_q[0] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q[g] <= 1'b0;
        else          sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tsen_settle_timer.sv
module tsen_settle_timer #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SHORT_US = 4,
  parameter int LONG_US  = 12
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic run_i,
  input  logic long_i,
  output logic done_o
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int LIM_SHORT  = SHORT_US * CYC_PER_US;
  localparam int LIM_LONG   = LONG_US * CYC_PER_US;
  localparam int LIM_MAX    = (LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT;
  localparam int CNT_W      = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LIM_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LIM_LONG - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last;

  assign last   = long_i ? LAST_LONG : LAST_SHORT;
  assign done_o = run_i && (cnt_q == last);
  assign cnt_en = clr_i || run_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tsen_fsm.sv
module tsen_fsm
  import tsen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        start_i,
  input  logic        en_i,
  input  logic        srst_i,
  input  logic        settle_done_i,
  output tsen_state_e state_o,
  output logic        accept_o,
  output logic        settling_o,
  output logic        sample_o
);
  tsen_state_e state_q, state_d;

  assign accept_o   = (state_q == ST_IDLE) && start_i && en_i && !srst_i;
  assign settling_o = (state_q == ST_SETTLE);
  assign sample_o   = (state_q == ST_SAMPLE) && !srst_i;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    if (srst_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (accept_o)      state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done_i) state_d = ST_SAMPLE;
        ST_SAMPLE:                    state_d = ST_DONE;
        ST_DONE:   if (!start_i)      state_d = ST_IDLE;
        default:                      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end
endmodule

// File: rtl/tsen_regs.sv
module tsen_regs
  import tsen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              accept_i,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              start_o,
  output logic              long_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              ready_o,
  output logic              ie_o
);
  logic              ctl_start_q, ctl_sel_q;
  logic [TRIM_W-1:0] ctl_trim_q;
  logic              lat_sel_q;
  logic [TRIM_W-1:0] lat_trim_q;
  logic              rdy_q, rdy_d, rdy_en;
  logic              ie_q;
  logic [CODE_W-1:0] res_q;
  logic              wr_ctrl, wr_stat;
  logic              unused_wdata;

  assign wr_ctrl      = wr_en_i && (addr_i == IDX_CTRL);
  assign wr_stat      = wr_en_i && (addr_i == IDX_STAT);
  assign unused_wdata = ^wdata_i;

  // control register
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctl_start_q <= 1'b0;
      ctl_sel_q   <= 1'b0;
      ctl_trim_q  <= '0;
    end else if (wr_ctrl) begin
      ctl_start_q <= wdata_i[CTL_START_BIT];
      ctl_sel_q   <= wdata_i[CTL_SEL_BIT];
      ctl_trim_q  <= wdata_i[CTL_TRIM_LSB +: TRIM_W];
    end
  end

  // per-measurement copy taken when a start is accepted
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lat_sel_q  <= 1'b0;
      lat_trim_q <= '0;
    end else if (accept_i) begin
      lat_sel_q  <= ctl_sel_q;
      lat_trim_q <= ctl_trim_q;
    end
  end

  // ready flag: completion sets, a zero written to bit 0 clears, set wins
  always_comb begin
    rdy_en = sample_i || (wr_stat && !wdata_i[STS_RDY_BIT]);
    rdy_d  = sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    rdy_q <= 1'b0;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     ie_q <= 1'b0;
    else if (wr_stat) ie_q <= wdata_i[STS_IE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      res_q <= '0;
    else if (sample_i) res_q <= code_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_CTRL: begin
        rdata_o[CTL_START_BIT]              = ctl_start_q;
        rdata_o[CTL_SEL_BIT]                = ctl_sel_q;
        rdata_o[CTL_TRIM_LSB +: TRIM_W]     = ctl_trim_q;
      end
      IDX_STAT: begin
        rdata_o[STS_RDY_BIT] = rdy_q;
        rdata_o[STS_IE_BIT]  = ie_q;
      end
      IDX_RES:  rdata_o[CODE_W-1:0] = res_q;
      default:  rdata_o = '0;
    endcase
  end

  assign start_o = ctl_start_q;
  assign long_o  = lat_sel_q;
  assign trim_o  = lat_trim_q;
  assign ready_o = rdy_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/tsen_seq.sv
module tsen_seq
  import tsen_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SHORT_US    = 4,
  parameter int LONG_US     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sens_en_i,
  input  logic              sens_rst_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              sample_o,
  output logic              irq_o
);
  logic        rst_n_sync;
  logic        ctl_start, lat_long, accept, settling, settle_done;
  logic        ready, ie, sample;
  tsen_state_e fsm_state;

  tsen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  tsen_regs u_regs (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_sync),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .accept_i (accept),
    .sample_i (sample),
    .code_i   (code_i),
    .start_o  (ctl_start),
    .long_o   (lat_long),
    .trim_o   (trim_o),
    .ready_o  (ready),
    .ie_o     (ie)
  );

  tsen_settle_timer #(
    .CLK_HZ   (CLK_HZ),
    .SHORT_US (SHORT_US),
    .LONG_US  (LONG_US)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_sync),
    .clr_i   (accept),
    .run_i   (settling),
    .long_i  (lat_long),
    .done_o  (settle_done)
  );

  tsen_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_sync),
    .start_i       (ctl_start),
    .en_i          (sens_en_i),
    .srst_i        (sens_rst_i),
    .settle_done_i (settle_done),
    .state_o       (fsm_state),
    .accept_o      (accept),
    .settling_o    (settling),
    .sample_o      (sample)
  );

  assign sample_o = sample;
  assign irq_o    = ready && ie;
endmodule

// File: rtl/tsen_seq_chk.sv
module tsen_seq_chk
  import tsen_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input tsen_state_e       state,
  input logic              start,
  input logic              sample,
  input logic              ready,
  input logic              irq,
  input logic [TRIM_W-1:0] trim,
  input logic              sens_en,
  input logic              sens_rst
);
  // R4
  sample_sets_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sample |=> ready);

  // R4
  sample_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sample |=> !sample);

  // R6
  irq_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> ready);

  // R7
  done_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_DONE && start && !sens_rst) |=> state == ST_DONE);

  // R8
  trim_held_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(trim));

  // R9
  srst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sens_rst |=> state == ST_IDLE);

  // R9
  srst_no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sens_rst |-> !sample);

  // R10
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == ST_IDLE && !sens_en) |=> state == ST_IDLE);
endmodule

bind tsen_seq tsen_seq_chk chk_i (
  .clk_i    (clk_i),
  .rst_n    (rst_n_sync),
  .state    (fsm_state),
  .start    (ctl_start),
  .sample   (sample_o),
  .ready    (ready),
  .irq      (irq_o),
  .trim     (trim_o),
  .sens_en  (sens_en_i),
  .sens_rst (sens_rst_i)
);

// File: tb/tsen_seq_tb_top.sv
module tsen_seq_tb_top;
  localparam int CLK_HZ  = 50_000_000;
  localparam int LIM_S   = 4 * (CLK_HZ / 1_000_000);
  localparam int LIM_L   = 12 * (CLK_HZ / 1_000_000);
  localparam int NVEC    = 4;
  // {ie, sel, trim[3:0], code[9:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'h3, 10'h155},
    {1'b0, 1'b1, 4'hC, 10'h3FF},
    {1'b1, 1'b1, 4'h0, 10'h000},
    {1'b0, 1'b0, 4'hF, 10'h2A7}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        sens_en, sens_rst;
  logic [9:0]  code;
  logic [3:0]  trim;
  logic        sample, irq;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  tsen_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .sens_en_i  (sens_en),
    .sens_rst_i (sens_rst),
    .code_i     (code),
    .trim_o     (trim),
    .sample_o   (sample),
    .irq_o      (irq)
  );

  always @(posedge clk) if (sample) pulses <= pulses + 1;

  function automatic logic [31:0] ctl(input bit st, input bit sel, input logic [3:0] tr);
    ctl = 32'(st) << 8 | 32'(sel) << 21 | 32'(tr) << 22;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(output int k);
    logic [31:0] s;
    k = 0;
    rd(2'd1, s);
    while (!s[0] && k < 5000) begin
      @(negedge clk); k++;
      rd(2'd1, s);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int k, p0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    sens_en = 1'b1; sens_rst = 1'b0; code = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd0, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(2'd1, r); chk(r == 0, "R1 status", r, 0);
    rd(2'd2, r); chk(r == 0, "R1 result", r, 0);
    chk(trim == 0 && irq == 0 && sample == 0, "R1 outputs", {trim, irq, sample}, 0);

    // R5 writing one to ready does not set it
    wr(2'd1, 32'h1);
    rd(2'd1, r); chk(r == 0, "R5 write-one no set", r, 0);

    // table-driven measurements
    for (int v = 0; v < NVEC; v++) begin
      logic ie, sel;
      logic [3:0] tr;
      logic [9:0] cd;
      {ie, sel, tr, cd} = VEC[v];
      code = cd;
      p0 = pulses;
      wr(2'd1, 32'(ie) << 1);
      wr(2'd0, ctl(1'b1, sel, tr));
      wait_ready(k);
      chk(k == (sel ? LIM_L : LIM_S) + 2, "R3 settle edges", k, (sel ? LIM_L : LIM_S) + 2);
      rd(2'd2, r); chk(r == 32'(cd), "R4 result", r, cd);
      chk(pulses == p0 + 1, "R4 one sample pulse", pulses - p0, 1);
      chk(trim == tr, "R8 trim driven", trim, tr);
      chk(irq == ie, "R6 irq with ready", irq, ie);
      rd(2'd0, r); chk(r == ctl(1'b1, sel, tr), "R2 ctrl readback", r, ctl(1'b1, sel, tr));
      wr(2'd1, 32'(ie) << 1);
      rd(2'd1, r); chk(r == 32'(ie) << 1, "R5 ready cleared", r, 32'(ie) << 1);
      chk(irq == 1'b0, "R6 irq after clear", irq, 0);
      wr(2'd0, 32'h0);
      idle(2);
    end

    // R7 start held high: no second measurement
    code = 10'h0AA;
    wr(2'd0, ctl(1'b1, 1'b0, 4'h1));
    wait_ready(k);
    wr(2'd1, 32'h0);
    p0 = pulses;
    idle(3 * LIM_S);
    rd(2'd1, r); chk(r == 0, "R7 no rerun ready", r, 0);
    chk(pulses == p0, "R7 no rerun sample", pulses - p0, 0);
    wr(2'd0, 32'h0);
    idle(2);
    wr(2'd0, ctl(1'b1, 1'b0, 4'h1));
    wait_ready(k);
    chk(k == LIM_S + 2, "R7 restart after drop", k, LIM_S + 2);
    wr(2'd1, 32'h0); wr(2'd0, 32'h0); idle(2);

    // R8 trim rewrite during settle
    wr(2'd0, ctl(1'b1, 1'b0, 4'h5));
    idle(10);
    wr(2'd0, ctl(1'b1, 1'b0, 4'hA));
    chk(trim == 4'h5, "R8 trim mid-settle", trim, 5);
    wait_ready(k);
    chk(trim == 4'h5, "R8 trim at done", trim, 5);
    rd(2'd0, r); chk(r == ctl(1'b1, 1'b0, 4'hA), "R2 trim field", r, ctl(1'b1, 1'b0, 4'hA));
    wr(2'd1, 32'h0); wr(2'd0, 32'h0); idle(2);

    // R9 sensor reset aborts a measurement
    p0 = pulses;
    wr(2'd0, ctl(1'b1, 1'b1, 4'h2));
    idle(20);
    sens_rst = 1'b1;
    idle(3);
    wr(2'd0, 32'h0);
    idle(2);
    sens_rst = 1'b0;
    idle(LIM_L + 10);
    rd(2'd1, r); chk(r == 0, "R9 abort no ready", r, 0);
    chk(pulses == p0, "R9 abort no sample", pulses - p0, 0);
    // R9 start while held in reset
    sens_rst = 1'b1;
    wr(2'd0, ctl(1'b1, 1'b0, 4'h2));
    idle(LIM_S + 10);
    rd(2'd1, r); chk(r == 0, "R9 held idle", r, 0);
    wr(2'd0, 32'h0);
    sens_rst = 1'b0;
    idle(2);

    // R10 sensor disabled
    p0 = pulses;
    sens_en = 1'b0;
    wr(2'd0, ctl(1'b1, 1'b0, 4'h7));
    idle(LIM_L + 10);
    rd(2'd1, r); chk(r == 0, "R10 disabled no ready", r, 0);
    chk(pulses == p0, "R10 disabled no sample", pulses - p0, 0);
    sens_en = 1'b1;
    wait_ready(k);
    chk(pulses == p0 + 1, "R10 runs after enable", pulses - p0, 1);
    chk(trim == 4'h7, "R10 trim latched", trim, 7);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule